// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block is a clocked, synthesizable model of a word-wide static memory with active-low controls: a chip select, a write strobe, an output gate and one enable per byte lane. Every control, the address and the input data are registered on each rising clock edge. The core then works out the operating mode from the sampled values: standby, read, write, or selected with outputs off. Each lane has its own data-out bus and its own drive-enable, so a pad ring or test harness can build a tristate bus from them. A standby flag reports when the chip select is inactive.

Writes work lane by lane. A lane takes part in a write only while chip select, write strobe and that lane's enable are all low together. The word is stored when that overlap ends, and it holds the data seen in the last sampled cycle of the overlap. The array depth is set by `ADDR_W`. The full-size configuration uses `ADDR_W = 16` (65,536 words of 16 bits). The default is kept smaller so that elaboration stays light.

Top module: `bsr_core`

## Requirements
- R1: The array holds 2**ADDR_W words of NUM_LANES x LANE_W bits; lane i occupies data bits [i*LANE_W +: LANE_W], and a word written at an address reads back unchanged from that address.
- R2: All inputs are sampled on the rising clock edge, and the outputs reflect the inputs sampled at the most recent edge, one cycle after they are applied.
- R3: With ce_n=0, oe_n=0 and we_n=1 sampled, dout_en[i] is 1 exactly when be_n[i]=0, and that lane presents the stored lane value; a lane whose dout_en is 0 presents zero on its dout bits.
- R4: dout_en is all zero whenever ce_n=1, oe_n=1, all be_n bits are 1, or a write is in progress (ce_n=0 with we_n=0).
- R5: we_n=0 overrides oe_n=0: with ce_n=0, we_n=0 and oe_n=0, no lane is driven and the write proceeds.
- R6: A write stores lane i only if be_n[i]=0; a lane whose enable is high keeps its previous contents.
- R7: A lane write ends at the first sampled cycle in which ce_n, we_n or that lane's be_n is high, or in which the address differs; the stored value is the data of the last sampled cycle before the end, and a read of that address in the ending cycle already returns it.
- R8: standby is 1 exactly when the most recently sampled ce_n is 1.
- R9: During reset, dout_en is zero and standby is 1; reset discards a write still in progress but leaves the array contents untouched.
- R10: With ce_n=0 and we_n=0 but both be_n bits high, the cycle changes no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| be_n | input | NUM_LANES | Per-lane byte enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | NUM_LANES*LANE_W | Write data |
| dout | output | NUM_LANES*LANE_W | Read data, zero on undriven lanes |
| dout_en | output | NUM_LANES | Per-lane drive enable for an external tristate |
| standby | output | 1 | High while the sampled chip select is inactive |

## Verification
The hardest case to reach from the ports is the end of a write. The stored value depends on which control rises first, or on whether the address moves while the strobes stay low, and on the data in the very last overlapping cycle. Directed sequences hold a write across several cycles with changing data. They then end it in four ways: by raising one lane enable while the other lane carries on, by moving the address, by raising the write strobe straight into a read of the same word, and by raising the chip select. Random traffic on a small address window keeps starting and ending overlapping lane writes, so these endings also come up against recently written words.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    BSR_STANDBY = 2'd0,
    BSR_READ    = 2'd1,
    BSR_WRITE   = 2'd2,
    BSR_QUIET   = 2'd3
  } bsr_mode_e;

endpackage

// File: rtl/bsr_sample.sv
module bsr_sample #(
  parameter int ADDR_W    = 10,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce_n,
  input  logic                        we_n,
  input  logic                        oe_n,
  input  logic [NUM_LANES-1:0]        be_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_LANES*LANE_W-1:0] din,
  output logic                        s_ce_n,
  output logic                        s_we_n,
  output logic                        s_oe_n,
  output logic [NUM_LANES-1:0]        s_be_n,
  output logic [ADDR_W-1:0]           s_addr,
  output logic [NUM_LANES*LANE_W-1:0] s_din
);

  // control inputs: reset to an inactive, deselected state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce_n <= 1'b1;
      s_we_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_be_n <= '1;
    end else begin
      s_ce_n <= ce_n;
      s_we_n <= we_n;
      s_oe_n <= oe_n;
      s_be_n <= be_n;
    end
  end

  // datapath inputs: no reset needed
  always_ff @(posedge clk) begin
    s_addr <= addr;
    s_din  <= din;
  end

endmodule

// File: rtl/bsr_decode.sv
module bsr_decode
  import bsr_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic                 s_ce_n,
  input  logic                 s_we_n,
  input  logic                 s_oe_n,
  input  logic [NUM_LANES-1:0] s_be_n,
  output bsr_mode_e            mode,
  output logic [NUM_LANES-1:0] lane_rd,
  output logic [NUM_LANES-1:0] lane_wr,
  output logic                 standby
);

  logic any_lane;

  always_comb begin
    any_lane = ~&s_be_n;
    if (s_ce_n) begin
      mode = BSR_STANDBY;
    end else if (!s_we_n) begin
      mode = any_lane ? BSR_WRITE : BSR_QUIET;
    end else if (!s_oe_n && any_lane) begin
      mode = BSR_READ;
    end else begin
      mode = BSR_QUIET;
    end
  end

  always_comb begin
    lane_rd = (mode == BSR_READ)  ? ~s_be_n : '0;
    lane_wr = (mode == BSR_WRITE) ? ~s_be_n : '0;
    standby = (mode == BSR_STANDBY);
  end

endmodule

// File: rtl/bsr_lane.sv
module bsr_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [LANE_W-1:0] s_din,
  input  logic              lane_wr,
  input  logic              lane_rd,
  output logic [LANE_W-1:0] rd_data,
  output logic              drive_en
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  logic              pend_act_q, pend_act_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic [LANE_W-1:0] pend_data_q, pend_data_d;
  logic              addr_same;
  logic              finish;
  logic [LANE_W-1:0] word;

  // next-state: a pending write closes when the overlap drops or the address moves
  always_comb begin
    addr_same   = (s_addr == pend_addr_q);
    finish      = pend_act_q && (!lane_wr || !addr_same);
    pend_act_d  = lane_wr;
    pend_addr_d = lane_wr ? s_addr : pend_addr_q;
    pend_data_d = lane_wr ? s_din  : pend_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_act_q <= 1'b0;
    end else begin
      pend_act_q <= pend_act_d;
    end
  end

  always_ff @(posedge clk) begin
    pend_addr_q <= pend_addr_d;
    pend_data_q <= pend_data_d;
  end

  // commit at the end of the overlap
  always_ff @(posedge clk) begin
    if (finish) begin
      mem[pend_addr_q] <= pend_data_q;
    end
  end

  // read path with forwarding of the word being committed this cycle
  always_comb begin
    word     = (finish && addr_same) ? pend_data_q : mem[s_addr];
    drive_en = lane_rd;
    rd_data  = lane_rd ? word : '0;
  end

endmodule

// File: rtl/bsr_core.sv
module bsr_core
  import bsr_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce_n,
  input  logic                        we_n,
  input  logic                        oe_n,
  input  logic [NUM_LANES-1:0]        be_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_LANES*LANE_W-1:0] din,
  output logic [NUM_LANES*LANE_W-1:0] dout,
  output logic [NUM_LANES-1:0]        dout_en,
  output logic                        standby
);

  logic                        rst_meta_n, rst_sync_n;
  logic                        s_ce_n, s_we_n, s_oe_n;
  logic [NUM_LANES-1:0]        s_be_n;
  logic [ADDR_W-1:0]           s_addr;
  logic [NUM_LANES*LANE_W-1:0] s_din;
  bsr_mode_e                   mode;
  logic [NUM_LANES-1:0]        lane_rd, lane_wr;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  bsr_sample #(
    .ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)
  ) u_sample (
    .clk(clk), .rst_n(rst_sync_n),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .be_n(be_n),
    .addr(addr), .din(din),
    .s_ce_n(s_ce_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n), .s_be_n(s_be_n),
    .s_addr(s_addr), .s_din(s_din)
  );

  bsr_decode #(
    .NUM_LANES(NUM_LANES)
  ) u_decode (
    .s_ce_n(s_ce_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n), .s_be_n(s_be_n),
    .mode(mode), .lane_rd(lane_rd), .lane_wr(lane_wr), .standby(standby)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    bsr_lane #(
      .ADDR_W(ADDR_W), .LANE_W(LANE_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_sync_n),
      .s_addr(s_addr),
      .s_din(s_din[g*LANE_W +: LANE_W]),
      .lane_wr(lane_wr[g]),
      .lane_rd(lane_rd[g]),
      .rd_data(dout[g*LANE_W +: LANE_W]),
      .drive_en(dout_en[g])
    );
  end

endmodule

// File: rtl/bsr_core_chk.sv
module bsr_core_chk #(
  parameter int ADDR_W    = 10,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 ce_n,
  input logic                 we_n,
  input logic                 oe_n,
  input logic [NUM_LANES-1:0] be_n,
  input logic [NUM_LANES-1:0] dout_en,
  input logic                 standby
);

  logic armed;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  AST_HIZ_IN_STANDBY: assert property (@(posedge clk) disable iff (!armed)
    standby |-> (dout_en == '0)); // R4

  AST_STANDBY_TRACKS_CE: assert property (@(posedge clk) disable iff (!armed)
    standby == $past(ce_n)); // R8

  AST_READ_LANES: assert property (@(posedge clk) disable iff (!armed)
    $past(!ce_n && !oe_n && we_n) |-> (dout_en == ~$past(be_n))); // R3

  AST_WRITE_BEATS_OE: assert property (@(posedge clk) disable iff (!armed)
    $past(!ce_n && !we_n) |-> (dout_en == '0)); // R5

  AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!armed)
    $past(oe_n) |-> (dout_en == '0)); // R4

endmodule

bind bsr_core bsr_core_chk #(
  .ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .be_n(be_n),
  .dout_en(dout_en), .standby(standby)
);

// File: tb/tb_bsr_core.sv
`timescale 1ns/1ps
module tb_bsr_core;

  localparam int AW = 10;
  localparam int NL = 2;
  localparam int LW = 8;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, we_n, oe_n;
  logic [NL-1:0] be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic [NL-1:0] dout_en;
  logic          standby;

  int checks = 0;
  int errors = 0;

  logic [LW-1:0] r_mem [NL][1 << AW];
  bit            r_val [NL][1 << AW];
  bit            p_act [NL];
  logic [AW-1:0] p_addr [NL];
  logic [LW-1:0] p_data [NL];

  always #2 clk = ~clk;

  bsr_core #(.ADDR_W(AW), .NUM_LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .be_n(be_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .standby(standby)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one cycle: drive at a falling edge, check at the next falling edge
  task automatic step(input logic c, input logic w, input logic o,
                      input logic [NL-1:0] b, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string note);
    logic [NL-1:0] exp_en;
    ce_n = c; we_n = w; oe_n = o; be_n = b; addr = a; din = d;
    @(negedge clk);
    for (int i = 0; i < NL; i++) begin
      bit wl;
      wl = !c && !w && !b[i];
      if (p_act[i] && (!wl || a != p_addr[i])) begin
        r_mem[i][p_addr[i]] = p_data[i];
        r_val[i][p_addr[i]] = 1'b1;
      end
      p_act[i] = wl;
      if (wl) begin
        p_addr[i] = a;
        p_data[i] = d[i*LW +: LW];
      end
      exp_en[i] = !c && w && !o && !b[i];
    end
    chk(dout_en == exp_en, {note, " R2 R3 R4 R5 lane enables"}, dout_en, exp_en);
    chk(standby == c, {note, " R8 standby"}, standby, c);
    for (int i = 0; i < NL; i++) begin
      if (!exp_en[i])
        chk(dout[i*LW +: LW] == '0, {note, " R3 idle lane zero"}, dout[i*LW +: LW], 0);
      else if (r_val[i][a])
        chk(dout[i*LW +: LW] == r_mem[i][a], {note, " R1 R6 R7 R10 read data"},
            dout[i*LW +: LW], r_mem[i][a]);
    end
  endtask

  task automatic do_reset();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; be_n = '1; addr = '0; din = '0;
    rst_n = 1'b0;
    for (int i = 0; i < NL; i++) p_act[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(dout_en == '0, "R9 reset lanes off", dout_en, 0);
    chk(standby == 1'b1, "R9 reset standby", standby, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();

    // fill a small window with both lanes
    for (int a = 0; a < 16; a++)
      step(0, 0, 1, 2'b00, AW'(a), DW'(16'h1100 + a * 16'h0101), "fill");
    step(1, 1, 1, 2'b11, '0, '0, "fill end");

    // truth table rows
    step(1, 0, 0, 2'b00, 10'd3, '0, "tt deselect");
    step(0, 1, 0, 2'b00, 10'd3, '0, "tt read both");
    step(0, 1, 0, 2'b10, 10'd4, '0, "tt read low");
    step(0, 1, 0, 2'b01, 10'd5, '0, "tt read high");
    step(0, 1, 1, 2'b00, 10'd5, '0, "tt oe off");
    step(0, 1, 0, 2'b11, 10'd5, '0, "tt lanes off");
    step(0, 0, 0, 2'b10, 10'd6, 16'hAAA5, "tt write low R5");
    step(0, 0, 1, 2'b01, 10'd7, 16'h5AAA, "tt write high");
    step(0, 1, 0, 2'b00, 10'd6, '0, "R6 readback");
    step(0, 1, 0, 2'b00, 10'd7, '0, "R6 readback");

    // R10: write strobe with no lanes enabled
    step(0, 0, 1, 2'b11, 10'd8, 16'hDEAD, "R10 no lanes");
    step(0, 1, 0, 2'b00, 10'd8, '0, "R10 readback");

    // R7: multi-cycle write, changing data, low lane ends first
    step(0, 0, 1, 2'b00, 10'd9, 16'h0102, "R7 hold");
    step(0, 0, 1, 2'b00, 10'd9, 16'h0304, "R7 hold");
    step(0, 0, 1, 2'b01, 10'd9, 16'h0506, "R7 low lane ends");
    step(0, 1, 0, 2'b00, 10'd9, '0, "R7 read in ending cycle");
    // R7: address moves during write
    step(0, 0, 1, 2'b00, 10'd10, 16'h7777, "R7 addr a");
    step(0, 0, 1, 2'b00, 10'd11, 16'h8888, "R7 addr b");
    step(1, 0, 1, 2'b00, 10'd11, 16'h9999, "R7 ce ends");
    step(0, 1, 0, 2'b00, 10'd10, '0, "R7 readback a");
    step(0, 1, 0, 2'b00, 10'd11, '0, "R7 readback b");

    // random traffic on the window
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r < 2, (r >= 2 && r < 7) ? 1'b0 : 1'b1, 1'($urandom) & (r == 15),
           NL'($urandom), AW'($urandom % 16), DW'($urandom), "rand");
    end
    step(1, 1, 1, 2'b11, '0, '0, "rand end");

    // R9: reset keeps contents
    do_reset();
    for (int a = 0; a < 16; a++)
      step(0, 1, 0, 2'b00, AW'(a), '0, "R9 after reset");

    summary();
  end

endmodule